// File: doc/BRIEF.md
# Streaming Sensor Sample Conditioner

This block is a peripheral on a low-speed APB bus. It cleans and shrinks a stream of signed 14-bit sensor samples with no processor work per sample. Each sample arrives on a valid/ready handshake. It passes through a fixed low-pass FIR filter and a lossy stage that keeps only the upper bits. The result then leaves on a second valid/ready handshake toward a buffer or an output port.

Software uses four APB registers to set the run parameters. It can turn the stream on or off, pick the order of the two stages and set how many upper bits survive. It can also reset the filter history, and it reads back status and the most recent result. Keeping 7 of the 14 bits halves the payload while keeping the waveform usable.

Top module: `sample_shaper`

## Requirements
- R1: After reset, register 0x00 reads 0 and register 0x04 reads 14. Register 0x08 reads 0 and register 0x0C reads 0. out_valid and in_ready are both low.
- R2: Register 0x00 holds three bits. Bit 0 is run, bit 1 is order and reads back. Bit 2 is a self-clearing clear and always reads 0. Register 0x04 holds the kept-bit count in bits 3:0, and a written value of 0 or above 14 is stored as 14.
- R3: pready is always high. pslverr is high only in the access phase of a transfer whose address is not 0x00, 0x04, 0x08 or 0x0C. Writes to 0x08 and 0x0C change nothing.
- R4: in_ready is high when run is set, no clear is being written, and the output register is empty or is being drained. A sample accepted at one clock edge appears on out_data with out_valid high after that same edge.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: The filter sees 14 taps. Tap 0 is the incoming sample and tap k is the sample accepted k samples earlier. The coefficients for taps 0 to 13 are -1, 0, 2, 4, 6, 8, 13, 13, 8, 6, 4, 2, 0, -1. The sum is formed at full precision, then 32 is added and the sum is arithmetically shifted right by 6. The result saturates to the range -8192..8191.
- R7: Truncation with count N keeps the N most significant bits of the 14-bit two's complement value and sets the lower 14-N bits to zero.
- R8: With order 0, the raw sample enters the delay line and the filter result is truncated. With order 1, the sample is truncated before it enters both the filter and the delay line, and the filter result is passed on without truncation. A change of order or count applies from the next accepted sample.
- R9: Status bit 1 (register 0x08) is set when an accepted sample's filter sum saturates. It stays set until a clear is written.
- R10: Status bit 2 is set once 13 samples have been accepted since reset or the last clear. A clear zeroes the delay line and clears bit 2.
- R11: Register 0x0C returns the most recent result in bits 13:0, with zeros above. Status bit 0 mirrors out_valid.
- R12: With run low, in_ready stays low. Samples offered on in_data are neither taken nor shifted into the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error for unmapped addresses |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample taken |
| in_data | input | 14 | Signed input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 14 | Signed processed result |

## Verification
The bench drives a pattern in which the newest and oldest taps sit at the negative limit while the middle taps sit at the positive limit. A filter without saturation, or with a misplaced negative tap, wraps the result or misses the sticky overflow flag. Both stage orders are exercised at narrow bit counts. A design that truncated at the wrong point, or pushed the raw sample in order 1, produces filtered values that differ from the model after a few samples. Backpressure, disabled input and the clear are all checked through later outputs. An output that drifted while stalled, a sample swallowed while disabled, or a delay line left dirty after a clear each shows up as a mismatched result.

// File: rtl/sp_pkg.sv
package sp_pkg;
    parameter int SW     = 14;
    parameter int TAPS   = 14;
    parameter int CW     = 16;
    parameter int SHIFT  = 6;
    localparam int GUARD = $clog2(TAPS);
    localparam int ACCW  = SW + CW + GUARD;
    localparam int KW    = $clog2(SW + 1);

    typedef logic signed [SW-1:0]   sample_t;
    typedef logic signed [ACCW-1:0] acc_t;
    typedef logic [KW-1:0]          keep_t;

    typedef struct packed {
        logic run;
        logic order;
    } ctrl_t;

    function automatic logic signed [CW-1:0] coef(input int k);
        case (k)
            0, 13:  coef = -16'sd1;
            1, 12:  coef = 16'sd0;
            2, 11:  coef = 16'sd2;
            3, 10:  coef = 16'sd4;
            4, 9:   coef = 16'sd6;
            5, 8:   coef = 16'sd8;
            default: coef = 16'sd13;
        endcase
    endfunction

    function automatic keep_t clamp_keep(input keep_t v);
        if (v == '0 || int'(v) > SW) clamp_keep = keep_t'(SW);
        else                         clamp_keep = v;
    endfunction

    function automatic sample_t keep_msbs(input sample_t x, input keep_t n);
        sample_t y;
        for (int i = 0; i < SW; i++)
            y[i] = (i >= SW - int'(n)) ? x[i] : 1'b0;
        return y;
    endfunction
endpackage

// File: rtl/sp_regs.sv
module sp_regs
    import sp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr,
    input  logic              stat_valid,
    input  logic              stat_warm,
    input  logic              sat_evt,
    input  sample_t           last_res,
    output ctrl_t             ctrl,
    output keep_t             keep_n,
    output logic              clr
);
    logic       access, mapped, wr, ovf;
    logic [1:0] idx;

    assign access  = psel & penable;
    assign mapped  = (paddr[ADDR_W-1:4] == '0) && (paddr[1:0] == 2'b00);
    assign idx     = paddr[3:2];
    assign wr      = access & pwrite & mapped;
    assign pslverr = access & ~mapped;
    assign clr     = wr && (idx == 2'd0) && pwdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            keep_n <= keep_t'(SW);
            ovf    <= 1'b0;
        end else begin
            if (wr && idx == 2'd0) begin
                ctrl.run   <= pwdata[0];
                ctrl.order <= pwdata[1];
            end
            if (wr && idx == 2'd1)
                keep_n <= clamp_keep(pwdata[KW-1:0]);
            if (clr)          ovf <= 1'b0;
            else if (sat_evt) ovf <= 1'b1;
        end
    end

    always_comb begin
        prdata = '0;
        if (mapped) begin
            case (idx)
                2'd0:    prdata[1:0]    = {ctrl.order, ctrl.run};
                2'd1:    prdata[KW-1:0] = keep_n;
                2'd2:    prdata[2:0]    = {stat_warm, ovf, stat_valid};
                default: prdata[SW-1:0] = last_res;
            endcase
        end
    end
endmodule

// File: rtl/sp_fir.sv
module sp_fir
    import sp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    push,
    input  sample_t din,
    output sample_t y,
    output logic    sat,
    output logic    warm
);
    localparam acc_t SMAX = acc_t'(2 ** (SW - 1) - 1);
    localparam acc_t SMIN = -acc_t'(2 ** (SW - 1));
    localparam acc_t RND  = acc_t'(2 ** (SHIFT - 1));
    localparam int   CNTW = $clog2(TAPS);

    sample_t         hist [TAPS-1];
    acc_t            prod [TAPS];
    acc_t            sum, scaled;
    logic [CNTW-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
            fill <= '0;
        end else if (push) begin
            hist[0] <= din;
            for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
            if (int'(fill) < TAPS - 1) fill <= fill + 1'b1;
        end
    end

    assign warm = (int'(fill) == TAPS - 1);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_new
            assign prod[k] = acc_t'(din) * acc_t'(coef(k));
        end else begin : g_old
            assign prod[k] = acc_t'(hist[k-1]) * acc_t'(coef(k));
        end
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < TAPS; k++) sum = sum + prod[k];
        scaled = (sum + RND) >>> SHIFT;
        sat = 1'b0;
        if (scaled > SMAX) begin
            y = sample_t'(SMAX); sat = 1'b1;
        end else if (scaled < SMIN) begin
            y = sample_t'(SMIN); sat = 1'b1;
        end else begin
            y = sample_t'(scaled);
        end
    end
endmodule

// File: rtl/sp_outreg.sv
module sp_outreg
    import sp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t din,
    input  logic    out_ready,
    output logic    out_valid,
    output sample_t out_data,
    output logic    free
);
    assign free = ~out_valid | out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= din;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_shaper.sv
module sample_shaper
    import sp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SW-1:0]     in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SW-1:0]     out_data
);
    ctrl_t   ctrl;
    keep_t   keep_n;
    logic    clr, free, accept, sat, warm, en;
    sample_t line_in, fir_y, result, last_res, odata;

    assign pready   = 1'b1;
    assign en       = ctrl.run;
    assign in_ready = en & ~clr & free;
    assign accept   = in_valid & in_ready;
    assign line_in  = ctrl.order ? keep_msbs(sample_t'(in_data), keep_n) : sample_t'(in_data);
    assign result   = ctrl.order ? fir_y : keep_msbs(fir_y, keep_n);
    assign out_data = odata;

    always_ff @(posedge clk) begin
        if (rst)         last_res <= '0;
        else if (accept) last_res <= result;
    end

    sp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .stat_valid(out_valid), .stat_warm(warm), .sat_evt(accept & sat),
        .last_res(last_res), .ctrl(ctrl), .keep_n(keep_n), .clr(clr)
    );

    sp_fir u_fir (
        .clk(clk), .rst(rst), .clr(clr), .push(accept), .din(line_in),
        .y(fir_y), .sat(sat), .warm(warm)
    );

    sp_outreg u_out (
        .clk(clk), .rst(rst), .load(accept), .din(result), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(odata), .free(free)
    );
endmodule

// File: rtl/sp_check.sv
module sp_check #(
    parameter int ADDR_W = 12,
    parameter int SW     = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic [ADDR_W-1:0] paddr,
    input logic              pslverr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SW-1:0]     out_data,
    input logic              en
);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    assert_rise_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_err_phase_R3: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> psel && penable);

    assert_err_unmapped_R3: assert property (@(posedge clk) disable iff (rst)
        psel && penable && (paddr >= ADDR_W'(16)) |-> pslverr);

    assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (rst)
        !en |-> !in_ready);
endmodule

bind sample_shaper sp_check #(.ADDR_W(ADDR_W), .SW(sp_pkg::SW)) u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .paddr(paddr),
    .pslverr(pslverr), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .en(en)
);

// File: tb/test_sample_shaper.sv
module test_sample_shaper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        in_valid = 0, in_ready;
    logic [13:0] in_data = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [13:0] out_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [13:0] exp_q[$];
    logic [13:0] last_seen = '0;
    logic signed [13:0] hist [13];
    bit   cur_order = 0;
    int   cur_n = 14;

    always #2.5 clk = ~clk;

    sample_shaper i_sample_shaper (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int cf(input int k);
        int c [14] = '{-1, 0, 2, 4, 6, 8, 13, 13, 8, 6, 4, 2, 0, -1};
        return c[k];
    endfunction

    function automatic logic signed [13:0] trunc(input logic signed [13:0] x, input int n);
        logic [13:0] m = ~((14'd1 << (14 - n)) - 14'd1);
        return x & m;
    endfunction

    function automatic logic [13:0] model(input logic signed [13:0] x);
        logic signed [13:0] li, y;
        longint acc, r;
        li  = cur_order ? trunc(x, cur_n) : x;
        acc = longint'(li) * cf(0);
        for (int k = 1; k < 14; k++) acc += longint'(hist[k-1]) * cf(k);
        r = (acc + 32) >>> 6;
        if (r > 8191) r = 8191;
        else if (r < -8192) r = -8192;
        y = 14'(r);
        for (int k = 12; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = li;
        return cur_order ? y : trunc(y, cur_n);
    endfunction

    task automatic clear_model();
        for (int k = 0; k < 13; k++) hist[k] = '0;
    endtask

    task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(negedge clk);
        rd = prdata; err = pslverr;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic e;
        apb(1, a, d, rd, e);
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] rd);
        logic e;
        apb(0, a, 0, rd, e);
    endtask

    task automatic send(input logic signed [13:0] x);
        @(posedge clk); #1;
        in_valid = 1; in_data = x;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        exp_q.push_back(model(x));
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected output", out_data, 0);
            end else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R6/R7/R8 result", $signed(out_data), $signed(e));
            end
            last_seen = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic e;
        clear_model();
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(in_ready == 0, "R1 in_ready", in_ready, 0);
        rreg(12'h000, rd); check(rd == 0, "R1 ctrl", rd, 0);
        rreg(12'h004, rd); check(rd == 14, "R1 keep count", rd, 14);
        rreg(12'h008, rd); check(rd == 0, "R1 status", rd, 0);
        rreg(12'h00C, rd); check(rd == 0, "R1 last", rd, 0);

        // R2 clamp of kept-bit count
        wreg(12'h004, 0);  rreg(12'h004, rd); check(rd == 14, "R2 clamp 0", rd, 14);
        wreg(12'h004, 15); rreg(12'h004, rd); check(rd == 14, "R2 clamp 15", rd, 14);
        wreg(12'h004, 7);  rreg(12'h004, rd); check(rd == 7, "R2 keep 7", rd, 7);
        wreg(12'h004, 14);
        wreg(12'h000, 32'h6); rreg(12'h000, rd); check(rd == 2, "R2 order bit, clear reads 0", rd, 2);
        wreg(12'h000, 0);

        // R3 APB error and read-only registers
        apb(0, 12'h010, 0, rd, e); check(e == 1, "R3 pslverr unmapped", e, 1);
        apb(0, 12'h004, 0, rd, e); check(e == 0, "R3 pslverr mapped", e, 0);
        check(pready == 1, "R3 pready", pready, 1);
        wreg(12'h008, 32'hFFFF); wreg(12'h00C, 32'h3FFF);
        rreg(12'h008, rd); check(rd == 0, "R3 status write ignored", rd, 0);
        rreg(12'h00C, rd); check(rd == 0, "R3 last write ignored", rd, 0);

        // R6 and R10: pure filter, warm-up
        wreg(12'h000, 1); cur_order = 0; cur_n = 14;
        for (int i = 0; i < 12; i++) send(14'(i * 311 - 1500));
        drain();
        rreg(12'h008, rd); check(rd[2] == 0, "R10 warm low after 12", rd[2], 0);
        send(14'sd2000);
        drain();
        rreg(12'h008, rd); check(rd[2] == 1, "R10 warm after 13", rd[2], 1);
        for (int i = 0; i < 10; i++) send((i % 2) ? 14'sd4000 : -14'sd4000);

        // R7 truncation to 7 bits, order 0
        wreg(12'h004, 7); cur_n = 7;
        for (int i = 0; i < 10; i++) send(14'(i * 733 - 3000));

        // R8 order 1 with 5 bits
        wreg(12'h004, 5); cur_n = 5;
        wreg(12'h000, 3); cur_order = 1;
        for (int i = 0; i < 14; i++) send(14'(6000 - i * 877));

        // R5 backpressure
        @(posedge clk); #1 out_ready = 0;
        send(14'sd1234);
        @(negedge clk);
        begin
            logic [13:0] held;
            held = out_data;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(out_valid == 1 && out_data == held, "R5 hold", out_data, held);
                check(in_ready == 0, "R4 in_ready low when full", in_ready, 0);
            end
        end
        @(posedge clk); #1 out_ready = 1;
        drain();

        // R12 disabled input is ignored
        wreg(12'h000, 2);
        @(posedge clk); #1 in_valid = 1; in_data = 14'sd5000;
        repeat (4) begin
            @(negedge clk);
            check(in_ready == 0, "R12 in_ready low", in_ready, 0);
            check(out_valid == 0, "R12 no output", out_valid, 0);
        end
        @(posedge clk); #1 in_valid = 0;
        wreg(12'h000, 3);
        send(-14'sd777);

        // R9 saturation and sticky flag, R10 clear
        wreg(12'h004, 14); cur_n = 14;
        wreg(12'h000, 5); cur_order = 0; clear_model();
        drain();
        rreg(12'h008, rd); check(rd[2:1] == 0, "R10 clear drops warm", rd[2:1], 0);
        send(-14'sd8192);
        for (int i = 0; i < 12; i++) send(14'sd8191);
        send(-14'sd8192);
        drain();
        rreg(12'h008, rd); check(rd[1] == 1, "R9 overflow sticky", rd[1], 1);
        send(14'sd0);
        drain();
        rreg(12'h008, rd); check(rd[1] == 1, "R9 sticky holds", rd[1], 1);
        wreg(12'h000, 5); clear_model();
        drain();
        rreg(12'h008, rd); check(rd[2:1] == 0, "R9 clear resets flags", rd[2:1], 0);
        send(14'sd4000);
        drain();

        // R11 last result readback
        rreg(12'h00C, rd); check(rd == {18'b0, last_seen}, "R11 last result", rd, last_seen);
        rreg(12'h008, rd); check(rd[0] == 0, "R11 status valid mirrors idle", rd[0], 0);

        drain();
        check(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule